// File: doc/BRIEF.md
# Linear CORDIC Multiply-Divide Unit

This block computes either a fused multiply-add or a divide-add on signed fixed-point words, using the linear form of the CORDIC shift-and-add loop. Each iteration does one of two things, chosen by a single direction bit. Either it adds a right-shifted copy of the x operand to y and subtracts a power-of-two constant from z, or it does the opposite. The loop itself is the same in both modes. In multiply mode the direction follows the sign of z, which drives z toward zero and leaves y holding y0 + x0·z0. In divide mode the direction follows the sign of y relative to x0, which drives y toward zero and leaves z holding z0 + y0/x0.

A caller presents the three operands and a mode bit together with a one-cycle start strobe. The unit then runs one iteration per clock and raises a one-cycle done flag. The result word stays valid until the next accepted start. Words are two's complement with one integer (sign) bit, so a word value w stands for w / 2^FRAC_W. The y path carries extra low-order guard bits so that the truncation of the shifted x term does not build up across iterations.

Top module: `cordic_lin_muldiv`

## Requirements
- R1: While reset is held and right after it is released, busy and done are 0 and result is 0.
- R2: A start seen on a clock edge while busy is 0 captures xIn, yIn, zIn and divMode on that edge, and busy is 1 in the following cycle. Later changes on these inputs have no effect on the running operation.
- R3: done is 1 for exactly one cycle, in the cycle after the ITERS+1-th clock edge counted from the edge that accepted start. busy drops to 0 in that same cycle.
- R4: A start seen while busy is 1 is ignored: the running operation keeps its timing and its result.
- R5: With divMode = 0 (multiply), and inputs with 0 < z0 < 1 and |y0 + x0·z0| < 1, result equals y0 + x0·z0 rounded to FRAC_W fraction bits within ±2 LSB. This holds for either sign of x0 and y0.
- R6: With divMode = 1 (divide), and inputs with |x0| ≥ 1/4 and |y0| ≤ |x0|/2, result equals z0 + y0/x0 within ±2 LSB. This holds for both signs of x0.
- R7: Multiply mode reaches both ends of the z0 range: the smallest value z0 = 2^-FRAC_W and the largest value z0 = 1 − 2^-FRAC_W, each within ±2 LSB.
- R8: While idle and without start, result holds its last value whatever the operand inputs do, and done stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation on this edge when idle |
| divMode | input | 1 | 0 = multiply-add, 1 = divide-add |
| xIn | input | DATA_W | Operand x0, signed, FRAC_W fraction bits |
| yIn | input | DATA_W | Operand y0, signed, FRAC_W fraction bits |
| zIn | input | DATA_W | Operand z0, signed, FRAC_W fraction bits |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when result becomes valid |
| result | output | DATA_W | y (multiply) or z (divide) after the last iteration |

## Verification
The bench builds the unit with its default settings: 24-bit words, 23 fraction bits, 8 guard bits and 23 iterations. These settings let a grid sweep cover both ends of the multiplier range, from a one-LSB z0 to the largest z0 below one. The same sweep covers both signs of x0 and y0, and quotient ratios of up to ±1/2 with divisors of either sign. Every operation in the sweep also has its latency counted, and further directed runs test that operands are captured on the start edge and that the result holds while idle.

// File: rtl/cordic_lin_pkg.sv
package cordic_lin_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } lin_state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands and mode
    logic step;  // perform one shift-add iteration
  } lin_ctrl_t;

endpackage

// File: rtl/cordic_lin_ctrl.sv
module cordic_lin_ctrl
  import cordic_lin_pkg::*;
#(
  parameter int ITERS = 23,
  parameter int CNT_W = $clog2(ITERS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output lin_ctrl_t        ctrl,
  output logic [CNT_W-1:0] iterIdx,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(ITERS);

  lin_state_e       state;
  logic [CNT_W-1:0] iterReg;
  logic             doneReg;

  always_comb begin
    ctrl.load = start && (state == ST_IDLE);
    ctrl.step = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      iterReg <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (ctrl.load) begin
        state   <= ST_RUN;
        iterReg <= CNT_W'(1);
      end else if (state == ST_RUN) begin
        iterReg <= iterReg + CNT_W'(1);
        if (iterReg == LAST_ITER) begin
          state   <= ST_IDLE;
          doneReg <= 1'b1;
        end
      end
    end
  end

  assign iterIdx = iterReg;
  assign busy    = (state == ST_RUN);
  assign done    = doneReg;

endmodule

// File: rtl/cordic_lin_path.sv
module cordic_lin_path
  import cordic_lin_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int FRAC_W  = 23,
  parameter int GUARD_W = 8,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lin_ctrl_t         ctrl,
  input  logic [CNT_W-1:0]  iterIdx,
  input  logic              divMode,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] zIn,
  output logic [DATA_W-1:0] result
);

  // One headroom bit on both accumulators, guard bits below y and x
  localparam int ACC_W = DATA_W + GUARD_W + 1;
  localparam int Z_W   = DATA_W + 1;
  localparam logic [ACC_W-1:0] HALF_OUT = ACC_W'(1) << (GUARD_W - 1);

  logic signed [ACC_W-1:0] xAcc, yAcc, xShift, yNext, yRnd;
  logic signed [Z_W-1:0]   zAcc, zNext;
  logic        [Z_W-1:0]   zUnit;
  logic                    divLatched;
  logic                    stepUp;

  // x0 scaled by 2^-i with sign fill
  assign xShift = xAcc >>> iterIdx;

  // 2^-i in the z format: a single bit at position FRAC_W - i
  always_comb begin
    for (int k = 0; k < Z_W; k++) begin
      zUnit[k] = (int'(iterIdx) == (FRAC_W - k));
    end
  end

  // Direction: z sign for multiply, y sign against x sign for divide
  always_comb begin
    if (divLatched) stepUp = (yAcc[ACC_W-1] != xAcc[ACC_W-1]);
    else            stepUp = !zAcc[Z_W-1];
  end

  always_comb begin
    if (stepUp) begin
      yNext = yAcc + xShift;
      zNext = zAcc - $signed(zUnit);
    end else begin
      yNext = yAcc - xShift;
      zNext = zAcc + $signed(zUnit);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xAcc       <= '0;
      yAcc       <= '0;
      zAcc       <= '0;
      divLatched <= 1'b0;
    end else if (ctrl.load) begin
      xAcc       <= {xIn[DATA_W-1], xIn, {GUARD_W{1'b0}}};
      yAcc       <= {yIn[DATA_W-1], yIn, {GUARD_W{1'b0}}};
      zAcc       <= {zIn[DATA_W-1], zIn};
      divLatched <= divMode;
    end else if (ctrl.step) begin
      yAcc <= yNext;
      zAcc <= zNext;
    end
  end

  assign yRnd   = yAcc + $signed(HALF_OUT);
  assign result = divLatched ? zAcc[DATA_W-1:0] : yRnd[GUARD_W +: DATA_W];

endmodule

// File: rtl/cordic_lin_muldiv.sv
module cordic_lin_muldiv
  import cordic_lin_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int FRAC_W  = DATA_W - 1,
  parameter int GUARD_W = 8,
  parameter int ITERS   = FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              divMode,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] yIn,
  input  logic [DATA_W-1:0] zIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  localparam int CNT_W = $clog2(ITERS + 1);

  lin_ctrl_t        ctrl;
  logic [CNT_W-1:0] iterIdx;

  cordic_lin_ctrl #(
    .ITERS (ITERS),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ctrl    (ctrl),
    .iterIdx (iterIdx),
    .busy    (busy),
    .done    (done)
  );

  cordic_lin_path #(
    .DATA_W  (DATA_W),
    .FRAC_W  (FRAC_W),
    .GUARD_W (GUARD_W),
    .CNT_W   (CNT_W)
  ) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .iterIdx (iterIdx),
    .divMode (divMode),
    .xIn     (xIn),
    .yIn     (yIn),
    .zIn     (zIn),
    .result  (result)
  );

endmodule

// File: rtl/cordic_lin_muldiv_chk.sv
module cordic_lin_muldiv_chk #(
  parameter int DATA_W = 24,
  parameter int ITERS  = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result
);

  localparam int BC_W = $clog2(ITERS + 2);

  // Number of busy cycles seen since busy last was low
  logic [BC_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + BC_W'(1);
    else           busyCnt <= '0;
  end

  // R2: an accepted start makes the unit busy next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3: done lasts one cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: done comes with busy low, after exactly ITERS busy cycles
  p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && busyCnt == BC_W'(ITERS)));

  // R4: busy is not cut short, a start during the run changes nothing
  p_run_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busyCnt != BC_W'(ITERS - 1)) |=> busy);

  // R8: idle without start keeps the result
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));

  // R8: done only ends a run
  p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

endmodule

bind cordic_lin_muldiv cordic_lin_muldiv_chk #(
  .DATA_W (DATA_W),
  .ITERS  (ITERS)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/cordic_lin_muldiv_tb.sv
`timescale 1ns/1ps
module cordic_lin_muldiv_tb;

  localparam int DATA_W = 24;
  localparam int FRAC_W = 23;
  localparam int ITERS  = 23;
  localparam longint ONE = longint'(1) << FRAC_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              divMode = 1'b0;
  logic [DATA_W-1:0] xIn = '0;
  logic [DATA_W-1:0] yIn = '0;
  logic [DATA_W-1:0] zIn = '0;
  logic              busy, done;
  logic [DATA_W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cordic_lin_muldiv u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .divMode(divMode),
    .xIn(xIn), .yIn(yIn), .zIn(zIn),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string tag, input longint act, input longint exp, input longint tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", tag, act, exp, tol);
    end
  endtask

  function automatic longint resVal();
    return longint'($signed(result));
  endfunction

  function automatic longint mulRef(input longint x, input longint y, input longint z);
    return (y * ONE + x * z + (ONE / 2)) >>> FRAC_W;
  endfunction

  function automatic longint divRef(input longint x, input longint y, input longint z);
    return z + (y * ONE) / x;
  endfunction

  task automatic finishRun();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Launch one operation and wait for done; lat counts negedges after the start negedge
  task automatic runOp(input bit dm, input longint x, input longint y, input longint z,
                       output longint res, output int lat);
    @(negedge clk);
    divMode = dm; xIn = x[DATA_W-1:0]; yIn = y[DATA_W-1:0]; zIn = z[DATA_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    res = resVal();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    longint res, hold;
    int lat;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0, 0);
    check("R1 done in reset", done, 0, 0);
    check("R1 result in reset", resVal(), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result after reset", resVal(), 0, 0);
    check("R1 done after reset", done, 0, 0);

    // R5/R7 multiply sweep, R3 latency on every run
    for (int yi = -1; yi <= 1; yi++) begin
      for (int xi = 0; xi < 8; xi++) begin
        for (int zi = 0; zi < 8; zi++) begin
          longint x = -5872025 + longint'(xi) * 1677721;
          longint y = longint'(yi) * (ONE / 4);
          longint z = 1 + (longint'(zi) * (ONE - 2)) / 7;
          runOp(1'b0, x, y, z, res, lat);
          check("R3 latency multiply", lat, ITERS + 1, 0);
          if (zi == 0 || zi == 7) check("R7 multiply z0 edge", res, mulRef(x, y, z), 2);
          else                    check("R5 multiply", res, mulRef(x, y, z), 2);
        end
      end
    end

    // R6 divide sweep with both divisor signs
    for (int zi = -1; zi <= 1; zi++) begin
      for (int xi = 0; xi < 8; xi++) begin
        for (int m = -4; m <= 4; m++) begin
          longint mags[4] = '{ONE / 4, ONE / 2, (ONE * 3) / 4, (ONE * 9) / 10};
          longint x = (xi < 4) ? mags[xi] : -mags[xi - 4];
          longint y = (x * m) / 8;
          longint z = longint'(zi) * (ONE / 4);
          runOp(1'b1, x, y, z, res, lat);
          check("R3 latency divide", lat, ITERS + 1, 0);
          check("R6 divide", res, divRef(x, y, z), 2);
        end
      end
    end

    // R3: done lasts one cycle
    @(negedge clk);
    check("R3 done single cycle", done, 0, 0);
    check("R3 busy low after done", busy, 0, 0);

    // R2: operands and mode captured on the start edge only
    @(negedge clk);
    divMode = 1'b1; xIn = 24'(ONE / 2); yIn = 24'(ONE / 8); zIn = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1, 0);
    divMode = 1'b0; xIn = 24'h7FFFFF; yIn = 24'h400000; zIn = 24'h123456;
    lat = 1;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    check("R2 captured operands", resVal(), divRef(ONE / 2, ONE / 8, 0), 2);

    // R4: start during a run is ignored
    runOp(1'b0, 0, 0, 0, res, lat);
    @(negedge clk);
    divMode = 1'b0; xIn = 24'(ONE / 2); yIn = '0; zIn = 24'(ONE / 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    divMode = 1'b1; xIn = 24'(-ONE / 4); yIn = 24'(ONE / 16); zIn = 24'(ONE / 8);
    start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    check("R4 latency with extra start", lat, ITERS + 1, 0);
    check("R4 result of first operation", resVal(), mulRef(ONE / 2, 0, ONE / 2), 2);
    @(negedge clk);
    check("R4 no second run", busy, 0, 0);

    // R8: idle result holds while inputs move
    hold = resVal();
    for (int k = 0; k < 10; k++) begin
      xIn = 24'(k * 777); yIn = 24'(k * 31337); zIn = 24'(k * 4242); divMode = k[0];
      @(negedge clk);
      check("R8 result holds", resVal(), hold, 0);
      check("R8 done stays low", done, 0, 0);
    end

    finishRun();
  end

endmodule